// File: doc/BRIEF.md
# GCM Field Multiplier

This block multiplies two elements of the 128-bit Galois field used by GCM authentication and returns their product. Each operand enters as a 16-byte vector in GCM byte order. A single-cycle start strobe captures both operands. After a fixed number of cycles a one-cycle done pulse marks the product on the result port. The result then stays put until the next operation completes.

Inside, the operands are byte-reversed into the reflected-bit integer form. Four 64x64 carry-less partial products are accumulated in parallel, `STEP_BITS` multiplier bits per cycle. The cross terms are merged into the 256-bit product, which is shifted left by one bit. The shifted product is reduced modulo x^128 + x^7 + x^2 + x + 1 by a two-phase shift-and-XOR fold: left shifts of 63, 62 and 57, then right shifts of 1, 2 and 7. The reduced value is byte-reversed back onto the output.

Top module: `gfm_mult`

## Requirements
- R1: Byte k of each operand and of the result sits in bits [8k+7:8k] of its port. Byte 0 is the first byte of the field element, and bit 7 of byte 0 is the coefficient of x^0. Thus port value 128'h80 is the element 1.
- R2: When done pulses, the result equals the GCM field product of the two operands captured at the accepted start, reduced modulo x^128 + x^7 + x^2 + x + 1.
- R3: Reduction is exercised by x^127 (byte 15 = 8'h01, all other bytes zero) times x (byte 0 = 8'h40). The product must be x^7 + x^2 + x + 1, which is byte 0 = 8'hE1 with all other bytes zero.
- R4: Multiplying by the element 1 (byte 0 = 8'h80, all other bytes zero), in either operand position, returns the other operand unchanged.
- R5: If either operand is zero, the result is zero.
- R6: done is high for exactly one cycle. It is visible STEPS+1 clock edges after the edge that accepted start, where STEPS = 64/STEP_BITS.
- R7: A start that arrives while an operation is in progress is ignored. It changes neither that operation's result nor its timing, and it produces no extra done pulse.
- R8: After reset, done is 0 and the result is 0. The result changes only in the cycle where done is high, and it holds its value between operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start strobe; accepted only when idle |
| aIn | input | 128 | Operand A, byte k in bits [8k+7:8k] |
| bIn | input | 128 | Operand B, byte k in bits [8k+7:8k] |
| doneOut | output | 1 | One-cycle pulse when the result is ready |
| resOut | output | 128 | Product, byte k in bits [8k+7:8k] |

## Verification
The bench builds the block with STEP_BITS = 4. That gives sixteen accumulation steps and a latency of seventeen edges, which leaves room to inject a second start deep inside an operation and check that it is ignored. The stimulus covers several cases: the unit element in both positions, a zero operand, the x^127 times x case that forces a carry out of the top bit through the fold, and a published GCM product vector. Pseudorandom pairs are checked against a bit-serial right-shift model of the field multiply written in the bench.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

  localparam int LANE = 64;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } gfmStrobes_t;

  function automatic logic [127:0] byteSwap128(input logic [127:0] v);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) begin
      r[8*k +: 8] = v[8*(15-k) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/gfm_clmul_lane.sv
module gfm_clmul_lane #(
  parameter int STEP_BITS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic                        step,
  input  logic [gfm_pkg::LANE-1:0]    mcandIn,
  input  logic [gfm_pkg::LANE-1:0]    mplierIn,
  output logic [2*gfm_pkg::LANE-1:0]  prodOut
);
  localparam int W = gfm_pkg::LANE;

  logic [2*W-1:0] acc;
  logic [2*W-1:0] mcandSh;
  logic [W-1:0]   mplier;
  logic [2*W-1:0] accNext;

  always_comb begin
    accNext = acc;
    for (int j = 0; j < STEP_BITS; j++) begin
      if (mplier[j]) accNext = accNext ^ (mcandSh << j);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      mcandSh <= '0;
      mplier  <= '0;
    end else if (load) begin
      acc     <= '0;
      mcandSh <= {{W{1'b0}}, mcandIn};
      mplier  <= mplierIn;
    end else if (step) begin
      acc     <= accNext;
      mcandSh <= mcandSh << STEP_BITS;
      mplier  <= mplier >> STEP_BITS;
    end
  end

  assign prodOut = acc;
endmodule

// File: rtl/gfm_datapath.sv
module gfm_datapath #(
  parameter int STEP_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  gfm_pkg::gfmStrobes_t ctl,
  input  logic [127:0]         aIn,
  input  logic [127:0]         bIn,
  output logic [127:0]         resOut
);
  localparam int W = gfm_pkg::LANE;

  logic [127:0] aInt, bInt;
  logic [2*W-1:0] lanePrd [4];

  assign aInt = gfm_pkg::byteSwap128(aIn);
  assign bInt = gfm_pkg::byteSwap128(bIn);

  // lane 0: a0*b0, lane 1: a1*b1, lane 2: a0*b1, lane 3: a1*b0
  for (genvar g = 0; g < 4; g++) begin : gLane
    logic [W-1:0] aSel, bSel;
    assign aSel = (g == 1 || g == 3) ? aInt[127:64] : aInt[63:0];
    assign bSel = (g == 1 || g == 2) ? bInt[127:64] : bInt[63:0];
    gfm_clmul_lane #(.STEP_BITS(STEP_BITS)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(ctl.load), .step(ctl.step),
      .mcandIn(aSel), .mplierIn(bSel), .prodOut(lanePrd[g])
    );
  end

  logic [127:0] crossSum, loHalf, hiHalf;
  logic [255:0] shiftedPrd;
  logic [W-1:0] x0, x1, x2, x3, dWord, hLo, hHi;
  logic [127:0] folded;

  always_comb begin
    crossSum   = lanePrd[2] ^ lanePrd[3];
    loHalf     = lanePrd[0] ^ {crossSum[63:0], 64'b0};
    hiHalf     = lanePrd[1] ^ {64'b0, crossSum[127:64]};
    shiftedPrd = {hiHalf, loHalf} << 1;
    x0 = shiftedPrd[63:0];
    x1 = shiftedPrd[127:64];
    x2 = shiftedPrd[191:128];
    x3 = shiftedPrd[255:192];
    dWord = x1 ^ (x0 << 63) ^ (x0 << 62) ^ (x0 << 57);
    hLo = x0 ^ (x0 >> 1) ^ (x0 >> 2) ^ (x0 >> 7)
          ^ (dWord << 63) ^ (dWord << 62) ^ (dWord << 57);
    hHi = dWord ^ (dWord >> 1) ^ (dWord >> 2) ^ (dWord >> 7);
    folded = {x3 ^ hHi, x2 ^ hLo};
  end

  logic [127:0] resReg;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          resReg <= '0;
    else if (ctl.finish) resReg <= folded;
  end

  assign resOut = gfm_pkg::byteSwap128(resReg);
endmodule

// File: rtl/gfm_ctrl.sv
module gfm_ctrl #(
  parameter int STEPS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 startIn,
  output gfm_pkg::gfmStrobes_t ctl,
  output logic                 doneOut
);
  localparam int CW = $clog2(STEPS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FOLD} state_t;
  state_t state;
  logic [CW-1:0] stepCnt;

  always_comb begin
    ctl.load   = (state == ST_IDLE) && startIn;
    ctl.step   = (state == ST_RUN);
    ctl.finish = (state == ST_FOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= ctl.finish;
      case (state)
        ST_IDLE: if (startIn) begin
          state   <= ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CW'(STEPS - 1)) state <= ST_FOLD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gfm_mult.sv
module gfm_mult #(
  parameter int STEP_BITS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         startIn,
  input  logic [127:0] aIn,
  input  logic [127:0] bIn,
  output logic         doneOut,
  output logic [127:0] resOut
);
  localparam int STEPS = gfm_pkg::LANE / STEP_BITS;

  gfm_pkg::gfmStrobes_t ctl;

  gfm_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startIn(startIn), .ctl(ctl), .doneOut(doneOut)
  );

  gfm_datapath #(.STEP_BITS(STEP_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .aIn(aIn), .bIn(bIn), .resOut(resOut)
  );
endmodule

// File: rtl/gfm_mult_chk.sv
module gfm_mult_chk #(
  parameter int STEP_BITS = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         startIn,
  input logic [127:0] aIn,
  input logic [127:0] bIn,
  input logic         doneOut,
  input logic [127:0] resOut
);
  localparam int STEPS = 64 / STEP_BITS;
  localparam logic [127:0] UNIT = 128'h80;

  int unsigned runCnt;
  logic [127:0] aCap, bCap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runCnt <= 0;
      aCap   <= '0;
      bCap   <= '0;
    end else if (runCnt == 0) begin
      if (startIn) begin
        runCnt <= 1;
        aCap   <= aIn;
        bCap   <= bIn;
      end
    end else if (runCnt == STEPS + 1) begin
      runCnt <= 0;
    end else begin
      runCnt <= runCnt + 1;
    end
  end

  AST_DONE_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    (runCnt == STEPS + 1) |=> doneOut); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |=> !doneOut); // R6
  AST_DONE_ONLY_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    doneOut |-> $past(runCnt == STEPS + 1)); // R7
  AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !doneOut |-> $stable(resOut)); // R8
  AST_UNIT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (doneOut && aCap == UNIT) |-> (resOut == bCap)); // R4
  AST_UNIT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (doneOut && bCap == UNIT) |-> (resOut == aCap)); // R4
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (doneOut && (aCap == '0 || bCap == '0)) |-> (resOut == '0)); // R5
endmodule

bind gfm_mult gfm_mult_chk #(.STEP_BITS(STEP_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .startIn(startIn), .aIn(aIn), .bIn(bIn),
  .doneOut(doneOut), .resOut(resOut)
);

// File: tb/gfm_mult_tb.sv
`timescale 1ns/1ps
module gfm_mult_tb;
  localparam int STEP_BITS = 4;
  localparam int STEPS = 64 / STEP_BITS;
  localparam int NTAB = 6;

  typedef struct packed {
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] e;
  } vec_t;

  // operands and expected values in big-endian integer form (byte 0 at MSB)
  localparam vec_t TAB [NTAB] = '{
    '{128'h80000000000000000000000000000000, 128'h0123456789abcdeffedcba9876543210,
      128'h0123456789abcdeffedcba9876543210},
    '{128'hdeadbeef00112233445566778899aabb, 128'h80000000000000000000000000000000,
      128'hdeadbeef00112233445566778899aabb},
    '{128'h0, 128'h5a5a5a5a5a5a5a5a5a5a5a5a5a5a5a5a, 128'h0},
    '{128'h00000000000000000000000000000001, 128'h40000000000000000000000000000000,
      128'he1000000000000000000000000000000},
    '{128'h40000000000000000000000000000000, 128'h40000000000000000000000000000000,
      128'h20000000000000000000000000000000},
    '{128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 128'h0388dace60b6a392f328c2b971b2fe78,
      128'h5e2ec746917062882c85b0685353deb7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startIn = 1'b0;
  logic [127:0] aIn = '0, bIn = '0;
  logic doneOut;
  logic [127:0] resOut;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  gfm_mult #(.STEP_BITS(STEP_BITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .startIn(startIn), .aIn(aIn), .bIn(bIn),
    .doneOut(doneOut), .resOut(resOut)
  );

  function automatic logic [127:0] bsw(input logic [127:0] v);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[8*k +: 8] = v[8*(15-k) +: 8];
    return r;
  endfunction

  function automatic logic [127:0] fieldMul(input logic [127:0] x, input logic [127:0] y);
    logic [127:0] z, v;
    z = '0;
    v = y;
    for (int i = 127; i >= 0; i--) begin
      if (x[i]) z = z ^ v;
      if (v[0]) v = (v >> 1) ^ {8'he1, 120'b0};
      else      v = v >> 1;
    end
    return z;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [127:0] aBe, input logic [127:0] bBe,
                       output logic [127:0] resBe, output int lat);
    @(negedge clk);
    startIn = 1'b1;
    aIn = bsw(aBe);
    bIn = bsw(bBe);
    @(negedge clk);
    startIn = 1'b0;
    lat = 0;
    while (!doneOut && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    resBe = bsw(resOut);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] res, exp, held, s1, s2;
    int lat;
    int idleDone;

    repeat (3) @(negedge clk);
    // R8 reset state
    check(doneOut == 1'b0, "R8 reset done", {127'b0, doneOut}, 128'h0);
    check(resOut == '0, "R8 reset result", resOut, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 with latency R6
    for (int t = 0; t < NTAB; t++) begin
      runOp(TAB[t].a, TAB[t].b, res, lat);
      check(res == TAB[t].e, $sformatf("R2 table entry %0d", t), res, TAB[t].e);
      check(lat == STEPS + 1, "R6 latency", 128'(lat), 128'(STEPS + 1));
    end

    // R1 port byte order: element 1 driven directly as 128'h80
    @(negedge clk);
    startIn = 1'b1;
    aIn = 128'h80;
    bIn = 128'h00112233445566778899aabbccddeeff;
    @(negedge clk);
    startIn = 1'b0;
    repeat (STEPS + 1) @(negedge clk);
    check(doneOut == 1'b1, "R6 done at expected cycle", {127'b0, doneOut}, 128'h1);
    check(resOut == 128'h00112233445566778899aabbccddeeff, "R1 raw port unit multiply",
          resOut, 128'h00112233445566778899aabbccddeeff);
    held = resOut;
    @(negedge clk);
    check(doneOut == 1'b0, "R6 done is single cycle", {127'b0, doneOut}, 128'h0);
    repeat (5) @(negedge clk);
    check(resOut == held, "R8 result holds while idle", resOut, held);

    // pseudorandom pairs against the bench model: R2
    s1 = 128'h3c6ef372fe94f82ba54ff53a5f1d36f1;
    s2 = 128'h510e527fade682d19b05688c2b3e6c1f;
    for (int n = 0; n < 8; n++) begin
      s1 = {s1[126:0], s1[127] ^ s1[125] ^ s1[100] ^ s1[98]} ^ (s2 << 3);
      s2 = {s2[0], s2[127:1]} ^ s1;
      runOp(s1, s2, res, lat);
      exp = fieldMul(s1, s2);
      check(res == exp, $sformatf("R2 random pair %0d", n), res, exp);
    end

    // R3 commuted reduction case
    runOp(128'h40000000000000000000000000000000, 128'h1, res, lat);
    check(res == 128'he1000000000000000000000000000000, "R3 x times x^127", res,
          128'he1000000000000000000000000000000);

    // R7 start while busy is ignored
    s1 = 128'hfedcba98765432100123456789abcdef;
    s2 = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    @(negedge clk);
    startIn = 1'b1;
    aIn = bsw(s1);
    bIn = bsw(s2);
    @(negedge clk);
    startIn = 1'b0;
    repeat (3) @(negedge clk);
    startIn = 1'b1;
    aIn = 128'h80;
    bIn = 128'h0;
    @(negedge clk);
    startIn = 1'b0;
    repeat (STEPS + 1 - 4) @(negedge clk);
    exp = fieldMul(s1, s2);
    check(doneOut == 1'b1, "R7 timing unchanged by late start", {127'b0, doneOut}, 128'h1);
    check(bsw(resOut) == exp, "R7 result of first operands", bsw(resOut), exp);
    idleDone = 0;
    for (int c = 0; c < STEPS + 6; c++) begin
      @(negedge clk);
      if (doneOut) idleDone++;
    end
    check(idleDone == 0, "R7 no extra done", 128'(idleDone), 128'h0);
    check(bsw(resOut) == exp, "R8 result held after ignored start", bsw(resOut), exp);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule